// File: doc/BRIEF.md
# Card Controller Register Front End

This block is the bus-facing register unit of a memory-card host controller. It decodes a 4 KiB word-addressed window. It holds the plain configuration registers and a status word. That word combines sticky event flags raised by the engines with live FIFO condition bits. A write-one-to-clear register acknowledges the sticky flags, and a set of mask registers each drive one interrupt line. It also serves a fixed identification window, a FIFO word-count readback and a FIFO data window.

The command and data engines sit outside this block. They reach it through narrow ports: a pop and push pair towards the data FIFO, a remaining-byte count, sticky-event pulses, live status bits, and a pass-through for the registers they own. After software drains a word through the FIFO data window, the block raises a hold signal that tells the data engine to stop moving data. Software releases the hold by reading the status or the FIFO-count register. This keeps fresh data from arriving while a slow driver is still draining the FIFO.

Reads are registered: read data and a valid flag appear on the clock edge that follows the request.

Top module: `sdx_regfront`

## Requirements
- R1: After reset, every stored register, the sticky flags, every mask and the hold signal are zero, and both interrupt lines are low.
- R2: The power (0x00) and clock (0x04) registers keep only bits 7:0 of a write. Argument (0x08), data timer (0x24) and data length (0x28) keep all 32 bits. A read returns data with `bus_rvalid` high in the cycle after the request.
- R3: Status (0x34) reads bits 10:0 as sticky flags, bits 21:11 as the live inputs, and bits 31:22 as zero. A pulse on an event input sets its flag, and the flag stays set until it is cleared.
- R4: A write to 0x38 clears each sticky flag whose bit in the written data is one. Only bits 10:0 take effect. An event pulse in the same cycle as the clear leaves its flag set.
- R5: Interrupt line i is high exactly when the status word ANDed with mask i (mask 0 at 0x3C, mask 1 at 0x40) is nonzero. It follows the clock edge that changes the status or the mask.
- R6: Reads from 0xFE0 to 0xFFF return one identification byte per word, in address order: 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R7: A read of 0x48 returns the remaining byte count plus 3, shifted right by 2.
- R8: A read in 0x80 to 0xBC while the FIFO is not empty pulses `fifo_pop` for that one cycle, returns `fifo_rdata`, and sets `data_hold`.
- R9: A read of status or of the FIFO count clears `data_hold`. A status read returns the value held before the read.
- R10: A read of the FIFO data window while the FIFO is empty returns zero, does not pop, and leaves `data_hold` unchanged.
- R11: A write to the FIFO data window pulses `fifo_push` with the written word when the byte count is nonzero, and is dropped when the count is zero.
- R12: Reads of unmapped offsets return zero. Writes to unmapped offsets or to read-only registers change no register and no interrupt line.
- R13: Writes to the command (0x0C) or data-control (0x2C) offsets pulse `eng_wr`. Reads of 0x0C, 0x10 to 0x20, 0x2C and 0x30 return `eng_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 12 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| eng_wr | output | 1 | Write strobe to an engine-owned register |
| eng_rdata | input | 32 | Read value of the engine-owned register at `bus_addr` |
| sts_set | input | 11 | One-cycle event pulses for sticky flags |
| sts_live | input | 11 | Live FIFO condition bits |
| byte_count | input | 16 | Remaining bytes of the data transfer |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | Remove the head word |
| fifo_push | output | 1 | Append `fifo_wdata` |
| fifo_wdata | output | 32 | Word to append |
| data_hold | output | 1 | Data engine must pause |
| irq | output | 2 | Masked interrupt lines |

## Verification
A flag wrongly kept or lost in the sticky register shows on an interrupt line on the next edge once its mask bit is set, and in the next status read. The bench keeps random masks, events and clears going, so such an error shows up within a few operations. A hold flag stuck high or low shows right away on `data_hold` after the triggering read. A wrong pop or push decision shows in the same cycle as the request. Decode errors show as a wrong word one cycle after the read, or as a change seen later when a register is read back.

// File: rtl/sdx_regfront_pkg.sv
package sdx_regfront_pkg;

  localparam int OFS_POWER  = 'h000;
  localparam int OFS_CLOCK  = 'h004;
  localparam int OFS_ARG    = 'h008;
  localparam int OFS_CMD    = 'h00C;
  localparam int OFS_RSP_LO = 'h010;
  localparam int OFS_RSP_HI = 'h020;
  localparam int OFS_TIMER  = 'h024;
  localparam int OFS_LEN    = 'h028;
  localparam int OFS_DCTL   = 'h02C;
  localparam int OFS_DCNT   = 'h030;
  localparam int OFS_STATUS = 'h034;
  localparam int OFS_CLEAR  = 'h038;
  localparam int OFS_MASK   = 'h03C;
  localparam int OFS_FCNT   = 'h048;
  localparam int OFS_FIFO   = 'h080;

  typedef enum logic [3:0] {
    RS_ZERO, RS_POWER, RS_CLOCK, RS_ARG, RS_TIMER, RS_LEN, RS_ENG,
    RS_STATUS, RS_MASK, RS_FCNT, RS_FIFO, RS_ID
  } rsel_e;

  typedef struct packed {
    logic power;
    logic clock;
    logic arg;
    logic timer;
    logic len;
    logic clr;
    logic eng;
  } wstb_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/sdx_addr_decode.sv
module sdx_addr_decode
  import sdx_regfront_pkg::*;
#(
  parameter int AW         = 12,
  parameter int NUM_IRQ    = 2,
  parameter int FIFO_WORDS = 16,
  parameter int CNT_W      = 16,
  localparam int IW        = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic               fifo_empty,
  input  logic [CNT_W-1:0]   byte_count,
  output rsel_e              rsel,
  output logic [IW-1:0]      mask_idx,
  output wstb_t              wstb,
  output logic [NUM_IRQ-1:0] mask_wr,
  output logic               fifo_pop,
  output logic               fifo_push,
  output logic               hold_clr
);

  localparam int FIFO_END = OFS_FIFO + 4 * FIFO_WORDS;

  logic fifo_hit, id_hit, eng_rd_hit, eng_wr_hit, mask_hit;

  assign fifo_hit   = (bus_addr >= AW'(OFS_FIFO)) && (bus_addr < AW'(FIFO_END));
  assign id_hit     = &bus_addr[AW-1:5];
  assign eng_wr_hit = (bus_addr == AW'(OFS_CMD)) || (bus_addr == AW'(OFS_DCTL));
  assign eng_rd_hit = eng_wr_hit || (bus_addr == AW'(OFS_DCNT)) ||
                      ((bus_addr >= AW'(OFS_RSP_LO)) && (bus_addr <= AW'(OFS_RSP_HI)) &&
                       (bus_addr[1:0] == 2'b00));

  always_comb begin
    mask_hit = 1'b0;
    mask_idx = '0;
    mask_wr  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (bus_addr == AW'(OFS_MASK + 4 * i)) begin
        mask_hit   = 1'b1;
        mask_idx   = IW'(i);
        mask_wr[i] = bus_wr;
      end
    end
  end

  always_comb begin
    if      (bus_addr == AW'(OFS_POWER))  rsel = RS_POWER;
    else if (bus_addr == AW'(OFS_CLOCK))  rsel = RS_CLOCK;
    else if (bus_addr == AW'(OFS_ARG))    rsel = RS_ARG;
    else if (bus_addr == AW'(OFS_TIMER))  rsel = RS_TIMER;
    else if (bus_addr == AW'(OFS_LEN))    rsel = RS_LEN;
    else if (bus_addr == AW'(OFS_STATUS)) rsel = RS_STATUS;
    else if (bus_addr == AW'(OFS_FCNT))   rsel = RS_FCNT;
    else if (eng_rd_hit)                  rsel = RS_ENG;
    else if (mask_hit)                    rsel = RS_MASK;
    else if (fifo_hit)                    rsel = RS_FIFO;
    else if (id_hit)                      rsel = RS_ID;
    else                                  rsel = RS_ZERO;
  end

  always_comb begin
    wstb.power = bus_wr && (bus_addr == AW'(OFS_POWER));
    wstb.clock = bus_wr && (bus_addr == AW'(OFS_CLOCK));
    wstb.arg   = bus_wr && (bus_addr == AW'(OFS_ARG));
    wstb.timer = bus_wr && (bus_addr == AW'(OFS_TIMER));
    wstb.len   = bus_wr && (bus_addr == AW'(OFS_LEN));
    wstb.clr   = bus_wr && (bus_addr == AW'(OFS_CLEAR));
    wstb.eng   = bus_wr && eng_wr_hit;
  end

  assign fifo_pop  = bus_rd && fifo_hit && !fifo_empty;
  assign fifo_push = bus_wr && fifo_hit && (byte_count != '0);
  assign hold_clr  = bus_rd && ((rsel == RS_STATUS) || (rsel == RS_FCNT));

endmodule

// File: rtl/sdx_status_irq.sv
module sdx_status_irq #(
  parameter int DW       = 32,
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int NUM_IRQ  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STICKY_W-1:0]   sts_set,
  input  logic [LIVE_W-1:0]     sts_live,
  input  logic                  clr_wr,
  input  logic [STICKY_W-1:0]   clr_bits,
  input  logic [NUM_IRQ-1:0]    mask_wr,
  input  logic [DW-1:0]         mask_wdata,
  output logic [DW-1:0]         status,
  output logic [NUM_IRQ*DW-1:0] mask_flat,
  output logic [NUM_IRQ-1:0]    irq
);

  logic [STICKY_W-1:0] sticky_q, sticky_d;
  logic [LIVE_W-1:0]   live_q;
  logic [DW-1:0]       status_d;

  always_comb begin
    sticky_d = sticky_q & ~(clr_wr ? clr_bits : '0);
    sticky_d = sticky_d | sts_set;
  end
  assign status_d = DW'({sts_live, sticky_d});

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      live_q   <= '0;
    end else begin
      sticky_q <= sticky_d;
      live_q   <= sts_live;
    end
  end
  assign status = DW'({live_q, sticky_q});

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [DW-1:0] mask_q, mask_d;
    logic          irq_q;
    assign mask_d = mask_wr[g] ? mask_wdata : mask_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        mask_q <= mask_d;
        irq_q  <= |(status_d & mask_d);
      end
    end
    assign mask_flat[g*DW +: DW] = mask_q;
    assign irq[g] = irq_q;

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
      irq[g] == |(status & mask_q)); // R5
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && sts_set == '0) |=> ((status[STICKY_W-1:0] & $past(clr_bits)) == '0)); // R4
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((status[STICKY_W-1:0] & $past(status[STICKY_W-1:0])) ==
                 $past(status[STICKY_W-1:0]))); // R3

endmodule

// File: rtl/sdx_regfront.sv
module sdx_regfront
  import sdx_regfront_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int NARROW_W   = 8,
  parameter int STICKY_W   = 11,
  parameter int LIVE_W     = 11,
  parameter int NUM_IRQ    = 2,
  parameter int FIFO_WORDS = 16,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_rvalid,
  output logic                eng_wr,
  input  logic [DW-1:0]       eng_rdata,
  input  logic [STICKY_W-1:0] sts_set,
  input  logic [LIVE_W-1:0]   sts_live,
  input  logic [CNT_W-1:0]    byte_count,
  input  logic                fifo_empty,
  input  logic [DW-1:0]       fifo_rdata,
  output logic                fifo_pop,
  output logic                fifo_push,
  output logic [DW-1:0]       fifo_wdata,
  output logic                data_hold,
  output logic [NUM_IRQ-1:0]  irq
);

  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  rsel_e                rsel;
  wstb_t                wstb;
  logic [IW-1:0]        mask_idx;
  logic [NUM_IRQ-1:0]   mask_wr;
  logic                 hold_clr;
  logic [DW-1:0]        status;
  logic [NUM_IRQ*DW-1:0] mask_flat;

  sdx_addr_decode #(
    .AW(AW), .NUM_IRQ(NUM_IRQ), .FIFO_WORDS(FIFO_WORDS), .CNT_W(CNT_W)
  ) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .fifo_empty(fifo_empty), .byte_count(byte_count),
    .rsel(rsel), .mask_idx(mask_idx), .wstb(wstb), .mask_wr(mask_wr),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .hold_clr(hold_clr)
  );

  sdx_status_irq #(
    .DW(DW), .STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .NUM_IRQ(NUM_IRQ)
  ) u_sts (
    .clk(clk), .rst(rst), .sts_set(sts_set), .sts_live(sts_live),
    .clr_wr(wstb.clr), .clr_bits(bus_wdata[STICKY_W-1:0]),
    .mask_wr(mask_wr), .mask_wdata(bus_wdata),
    .status(status), .mask_flat(mask_flat), .irq(irq)
  );

  logic [NARROW_W-1:0] power_q, clock_q;
  logic [DW-1:0]       arg_q, timer_q, len_q;
  logic                hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      power_q <= '0;
      clock_q <= '0;
      arg_q   <= '0;
      timer_q <= '0;
      len_q   <= '0;
      hold_q  <= 1'b0;
    end else begin
      if (wstb.power) power_q <= bus_wdata[NARROW_W-1:0];
      if (wstb.clock) clock_q <= bus_wdata[NARROW_W-1:0];
      if (wstb.arg)   arg_q   <= bus_wdata;
      if (wstb.timer) timer_q <= bus_wdata;
      if (wstb.len)   len_q   <= bus_wdata;
      if (fifo_pop)       hold_q <= 1'b1;
      else if (hold_clr)  hold_q <= 1'b0;
    end
  end

  assign data_hold  = hold_q;
  assign eng_wr     = wstb.eng;
  assign fifo_wdata = bus_wdata;

  logic [CNT_W:0] cnt_round;
  logic [DW-1:0]  rdata_d, rdata_q;
  logic           rvalid_q;

  assign cnt_round = {1'b0, byte_count} + (CNT_W + 1)'(3);

  always_comb begin
    case (rsel)
      RS_POWER:  rdata_d = DW'(power_q);
      RS_CLOCK:  rdata_d = DW'(clock_q);
      RS_ARG:    rdata_d = arg_q;
      RS_TIMER:  rdata_d = timer_q;
      RS_LEN:    rdata_d = len_q;
      RS_ENG:    rdata_d = eng_rdata;
      RS_STATUS: rdata_d = status;
      RS_MASK:   rdata_d = mask_flat[mask_idx*DW +: DW];
      RS_FCNT:   rdata_d = DW'(cnt_round >> 2);
      RS_FIFO:   rdata_d = fifo_empty ? '0 : fifo_rdata;
      RS_ID:     rdata_d = DW'(id_byte(bus_addr[4:2]));
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= bus_rd ? rdata_d : '0;
      rvalid_q <= bus_rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  AST_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> data_hold); // R8
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (hold_clr && !fifo_pop) |=> !data_hold); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty); // R10
  AST_PUSH_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (byte_count != '0)); // R11
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R2

endmodule

// File: tb/sdx_regfront_test.sv
module sdx_regfront_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, eng_wr;
  logic [31:0] eng_rdata = 32'hC0DE_0001;
  logic [10:0] sts_set = '0, sts_live = '0;
  logic [15:0] byte_count = '0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_rdata = '0;
  logic        fifo_pop, fifo_push, data_hold;
  logic [31:0] fifo_wdata;
  logic [1:0]  irq;

  always #4 clk = ~clk;

  sdx_regfront uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eng_wr(eng_wr), .eng_rdata(eng_rdata), .sts_set(sts_set), .sts_live(sts_live),
    .byte_count(byte_count), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .data_hold(data_hold), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  logic [10:0] m_sticky = '0, m_live = '0;
  logic [31:0] m_mask [2] = '{32'h0, 32'h0};
  logic        seen_pop, seen_push, seen_eng, rv;
  logic [31:0] seen_wdata, rd_val;

  function automatic logic [31:0] exp_status();
    return {10'b0, m_live, m_sticky};
  endfunction
  function automatic logic [1:0] exp_irq();
    return {|(exp_status() & m_mask[1]), |(exp_status() & m_mask[0])};
  endfunction
  function automatic logic [31:0] exp_id(input int k);
    logic [7:0] t [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'b0, t[k]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    seen_push = fifo_push; seen_eng = eng_wr; seen_wdata = fifo_wdata;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    seen_pop = fifo_pop;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; rv = bus_rvalid;
  endtask

  task automatic pulse_set(input logic [10:0] v);
    @(negedge clk);
    sts_set = v;
    @(negedge clk);
    sts_set = '0;
    m_sticky |= v;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {30'b0, irq}, 32'h0);
    chk("R1 hold", {31'b0, data_hold}, 32'h0);
    rd(12'h034, rd_val); chk("R1 status", rd_val, 32'h0);
    rd(12'h03C, rd_val); chk("R1 mask0", rd_val, 32'h0);
    rd(12'h008, rd_val); chk("R1 arg", rd_val, 32'h0);

    // R2 narrow and wide registers, read latency
    wr(12'h000, 32'hFFFF_F1A5); rd(12'h000, rd_val);
    chk("R2 power 8 bit", rd_val, 32'hA5);
    chk("R2 rvalid", {31'b0, rv}, 32'h1);
    wr(12'h004, 32'h0000_0133); rd(12'h004, rd_val); chk("R2 clock 8 bit", rd_val, 32'h33);
    wr(12'h008, 32'hDEAD_BEEF); rd(12'h008, rd_val); chk("R2 arg", rd_val, 32'hDEAD_BEEF);
    wr(12'h024, 32'h1234_5678); rd(12'h024, rd_val); chk("R2 timer", rd_val, 32'h1234_5678);
    wr(12'h028, 32'h8000_0200); rd(12'h028, rd_val); chk("R2 length", rd_val, 32'h8000_0200);

    // R6 identification window
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4 * k), rd_val);
      chk($sformatf("R6 id %0d", k), rd_val, exp_id(k));
    end

    // R7 FIFO count rounding
    begin
      logic [15:0] counts [5] = '{16'd0, 16'd1, 16'd4, 16'd5, 16'hFFFF};
      for (int k = 0; k < 5; k++) begin
        byte_count = counts[k];
        rd(12'h048, rd_val);
        chk("R7 fifo count", rd_val, (32'(counts[k]) + 32'd3) >> 2);
      end
    end

    // R8 / R10 / R9 hold-off sequence
    byte_count = 16'd64; fifo_empty = 1'b0; fifo_rdata = 32'hA1B2_C3D4;
    rd(12'h084, rd_val);
    chk("R8 pop pulse", {31'b0, seen_pop}, 32'h1);
    chk("R8 data", rd_val, 32'hA1B2_C3D4);
    chk("R8 hold set", {31'b0, data_hold}, 32'h1);
    fifo_empty = 1'b1;
    rd(12'h0BC, rd_val);
    chk("R10 empty data", rd_val, 32'h0);
    chk("R10 no pop", {31'b0, seen_pop}, 32'h0);
    chk("R10 hold kept", {31'b0, data_hold}, 32'h1);
    pulse_set(11'h040);
    rd(12'h034, rd_val);
    chk("R9 status value", rd_val, exp_status());
    chk("R9 hold cleared by status", {31'b0, data_hold}, 32'h0);
    fifo_empty = 1'b0;
    rd(12'h080, rd_val);
    chk("R8 hold set again", {31'b0, data_hold}, 32'h1);
    rd(12'h048, rd_val);
    chk("R9 hold cleared by count", {31'b0, data_hold}, 32'h0);
    fifo_empty = 1'b1;

    // R11 FIFO writes
    byte_count = 16'd5;
    wr(12'h0A0, 32'h5566_7788);
    chk("R11 push", {31'b0, seen_push}, 32'h1);
    chk("R11 push data", seen_wdata, 32'h5566_7788);
    byte_count = 16'd0;
    wr(12'h0A0, 32'h1111_2222);
    chk("R11 dropped", {31'b0, seen_push}, 32'h0);

    // R13 engine window
    wr(12'h00C, 32'h0000_0451); chk("R13 eng wr cmd", {31'b0, seen_eng}, 32'h1);
    wr(12'h02C, 32'h1);         chk("R13 eng wr dctl", {31'b0, seen_eng}, 32'h1);
    wr(12'h034, 32'hFFFF_FFFF); chk("R13 no eng wr on status", {31'b0, seen_eng}, 32'h0);
    rd(12'h010, rd_val); chk("R13 response read", rd_val, 32'hC0DE_0001);
    rd(12'h030, rd_val); chk("R13 data count read", rd_val, 32'hC0DE_0001);

    // R4 set beats clear in the same cycle; upper bits ignored
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'hFFFF_FFFF; sts_set = 11'h001;
    @(negedge clk);
    bus_wr = 1'b0; sts_set = '0;
    m_sticky = 11'h001;
    rd(12'h034, rd_val); chk("R4 set wins over clear", rd_val, exp_status());

    // R12 unmapped accesses
    wr(12'h03C, 32'h0000_0001); m_mask[0] = 32'h1;
    chk("R5 irq after mask", {30'b0, irq}, {30'b0, exp_irq()});
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h044, rd_val); chk("R12 unmapped read 044", rd_val, 32'h0);
    rd(12'h100, rd_val); chk("R12 unmapped read 100", rd_val, 32'h0);
    rd(12'h03C, rd_val); chk("R12 mask0 untouched", rd_val, 32'h1);
    rd(12'h000, rd_val); chk("R12 power untouched", rd_val, 32'hA5);
    chk("R12 irq untouched", {30'b0, irq}, {30'b0, exp_irq()});

    // Random mix: R3, R4, R5
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: pulse_set(11'($urandom & $urandom));
        1: begin
          logic [31:0] v;
          v = $urandom;
          wr(12'h038, v);
          m_sticky &= ~v[10:0];
        end
        2: begin
          int i;
          logic [31:0] v;
          i = int'($urandom % 2);
          v = $urandom & $urandom & $urandom;
          wr(12'(12'h03C + 4 * i), v);
          m_mask[i] = v;
        end
        3: begin
          @(negedge clk);
          sts_live = 11'($urandom);
          m_live = sts_live;
          @(negedge clk);
        end
        4: begin
          rd(12'h034, rd_val);
          chk("R3 status read", rd_val, exp_status());
        end
        default: begin
          int i;
          i = int'($urandom % 2);
          rd(12'(12'h03C + 4 * i), rd_val);
          chk("R5 mask read", rd_val, m_mask[i]);
        end
      endcase
      chk("R5 irq lines", {30'b0, irq}, {30'b0, exp_irq()});
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule